// File: doc/BRIEF.md
# Interrupt Entry and Return Stacking Sequencer

This block moves the processor context to and from a byte-wide stack on interrupt entry and on return from interrupt. When the interrupt controller acknowledges a request and the current instruction has finished, the sequencer captures the return address, both index registers, both accumulators and the condition code byte. It writes them one byte per clock to the stack port while it steps the stack pointer down. When the last byte is written it raises the maskable-interrupt mask, and on a non-maskable entry it also raises the non-maskable mask.

A return command runs the same nine slots backwards. It reads bytes upward from the given stack pointer and rebuilds every register from what it reads. This includes both mask bits, which come only from the stacked condition code byte. The host core presents its current stack pointer on `sp_in` at the start of either sequence and takes the updated pointer and registers from the outputs once `busy` drops. Vector fetch, priority arbitration and instruction decode belong to other blocks.

Top module: `irq_stack_seq`

## Requirements
- R1: An entry sequence starts only on a clock edge where the sequencer is idle and both `entry_req` and `instr_done` are high. `busy` is high from the following cycle. While `instr_done` is low, `entry_req` causes no port activity.
- R2: Entry writes nine bytes. Write k (k = 0..8) goes to address `sp_in - 1 - k`, so each push pre-decrements the pointer. The bytes, in write order, are: return address bits 7:0, return address bits 15:8, Y bits 7:0, Y bits 15:8, X bits 7:0, X bits 15:8, A, B, condition code byte.
- R3: Every push or pull takes exactly one clock cycle on the stack port. `busy` stays high for exactly nine consecutive cycles per sequence, and the port is used only while `busy` is high.
- R4: After entry, `sp_out` equals `sp_in - 9` modulo 2^16, which is the address of the stacked condition code byte.
- R5: The stacked condition code byte is `ccr_in` unchanged. After entry, `ccr_out` is that byte with bit 4 (maskable mask) set, and with bit 6 (non-maskable mask) also set when `entry_nmi` was high at acceptance.
- R6: Return reads nine bytes. Read k goes to address `sp_in + k`, so each pull post-increments the pointer. The order is: condition code byte first, then B, A, X high, X low, Y high, Y low, return high, and return low last. Afterwards `sp_out` equals `sp_in + 9` modulo 2^16.
- R7: After return, `pc_out`, `y_out`, `x_out`, `a_out`, `b_out` and `ccr_out` equal the bytes read from the stack, including bits 6 and 4 of the condition code. The input register values at that time have no effect.
- R8: A `ret_req` or `entry_req` that arrives while a sequence is running is ignored. The running sequence completes unchanged and no new sequence follows.
- R9: When the sequencer is idle and an entry (R1) and `ret_req` arrive in the same cycle, the entry is taken and the return is dropped.
- R10: `done` pulses high for one cycle, in the first cycle after the last byte transfer.
- R11: While reset is asserted and right after it, `busy`, `done`, `mem_we` and `mem_re` are low and all register outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_req | input | 1 | Interrupt acknowledge from the controller |
| entry_nmi | input | 1 | Acknowledged interrupt is non-maskable |
| instr_done | input | 1 | Current instruction has completed |
| ret_req | input | 1 | Return-from-interrupt command |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Return address to stack |
| y_in | input | 16 | Y index register |
| x_in | input | 16 | X index register |
| a_in | input | 8 | Accumulator A |
| b_in | input | 8 | Accumulator B |
| ccr_in | input | 8 | Condition code byte |
| mem_we | output | 1 | Stack port write strobe |
| mem_re | output | 1 | Stack port read strobe |
| mem_addr | output | 16 | Stack port address |
| mem_wdata | output | 8 | Stack port write data |
| mem_rdata | input | 8 | Stack port read data, valid in the same cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 16 | Updated stack pointer |
| pc_out | output | 16 | Return address register |
| y_out | output | 16 | Y register |
| x_out | output | 16 | X register |
| a_out | output | 8 | Accumulator A |
| b_out | output | 8 | Accumulator B |
| ccr_out | output | 8 | Condition code byte with mask bits |

## Verification
Inputs are applied at a falling edge. An accepted request shows its first port transfer one edge later, with `busy` high at the next falling edge. The bench compares address, strobe and data against the arithmetic slot list at each of the nine following falling edges. `sp_out`, the register outputs and `done` settle at the falling edge just after the ninth transfer, and the bench samples them there. Requests that should be ignored are applied before or inside a sequence, and the bench then checks that the strobes and the final outputs match what an untouched sequence gives.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int BYTE_W    = 8;
  localparam int REG_W     = 16;
  localparam int NUM_SLOTS = 9;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PUSH = 2'd1,
    SEQ_PULL = 2'd2
  } seq_mode_e;

  typedef struct packed {
    logic [REG_W-1:0]  pc;
    logic [REG_W-1:0]  y;
    logic [REG_W-1:0]  x;
    logic [BYTE_W-1:0] a;
    logic [BYTE_W-1:0] b;
    logic [BYTE_W-1:0] ccr;
  } cpu_ctx_t;

  // Slot k is the k-th byte written on entry.
  function automatic logic [BYTE_W-1:0] slot_get(cpu_ctx_t c, logic [SLOT_W-1:0] k);
    logic [BYTE_W-1:0] r;
    case (k)
      4'd0:    r = c.pc[7:0];
      4'd1:    r = c.pc[15:8];
      4'd2:    r = c.y[7:0];
      4'd3:    r = c.y[15:8];
      4'd4:    r = c.x[7:0];
      4'd5:    r = c.x[15:8];
      4'd6:    r = c.a;
      4'd7:    r = c.b;
      default: r = c.ccr;
    endcase
    return r;
  endfunction

  function automatic cpu_ctx_t slot_put(cpu_ctx_t c, logic [SLOT_W-1:0] k, logic [BYTE_W-1:0] d);
    cpu_ctx_t r;
    r = c;
    case (k)
      4'd0:    r.pc[7:0]  = d;
      4'd1:    r.pc[15:8] = d;
      4'd2:    r.y[7:0]   = d;
      4'd3:    r.y[15:8]  = d;
      4'd4:    r.x[7:0]   = d;
      4'd5:    r.x[15:8]  = d;
      4'd6:    r.a        = d;
      4'd7:    r.b        = d;
      default: r.ccr      = d;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/irqs_ctrl.sv
module irqs_ctrl
  import irqs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_req,
  input  logic              instr_done,
  input  logic              ret_req,
  output seq_mode_e         mode,
  output logic [SLOT_W-1:0] slot,
  output logic              take_entry,
  output logic              take_ret,
  output logic              last_step,
  output logic              done
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  seq_mode_e         mode_q, mode_d;
  logic [SLOT_W-1:0] cnt_q, cnt_d;
  logic              done_q, done_d;

  always_comb begin
    take_entry = (mode_q == SEQ_IDLE) && entry_req && instr_done;
    take_ret   = (mode_q == SEQ_IDLE) && ret_req && !take_entry;
    last_step  = (mode_q != SEQ_IDLE) && (cnt_q == LAST);
    mode_d     = mode_q;
    cnt_d      = cnt_q;
    done_d     = last_step;
    if (take_entry) begin
      mode_d = SEQ_PUSH;
      cnt_d  = '0;
    end else if (take_ret) begin
      mode_d = SEQ_PULL;
      cnt_d  = '0;
    end else if (mode_q != SEQ_IDLE) begin
      if (last_step) begin
        mode_d = SEQ_IDLE;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SEQ_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign mode = mode_q;
  assign slot = (mode_q == SEQ_PULL) ? (LAST - cnt_q) : cnt_q;
  assign done = done_q;
endmodule

// File: rtl/irqs_sp.sv
module irqs_sp
  import irqs_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_mode_e         mode,
  input  logic              load,
  input  logic [ADDR_W-1:0] sp_in,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] sp_out
);
  logic [ADDR_W-1:0] sp_q, sp_d;
  logic              sp_en;

  always_comb begin
    sp_en = 1'b1;
    sp_d  = sp_q;
    if (load) begin
      sp_d = sp_in;
    end else begin
      case (mode)
        SEQ_PUSH: sp_d = sp_q - 1'b1;
        SEQ_PULL: sp_d = sp_q + 1'b1;
        default:  sp_en = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

  assign addr   = (mode == SEQ_PUSH) ? (sp_q - 1'b1) : sp_q;
  assign sp_out = sp_q;
endmodule

// File: rtl/irqs_ctx.sv
module irqs_ctx
  import irqs_pkg::*;
#(
  parameter int I_BIT = 4,
  parameter int X_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_mode_e         mode,
  input  logic [SLOT_W-1:0] slot,
  input  logic              take_entry,
  input  logic              entry_nmi,
  input  logic              last_step,
  input  cpu_ctx_t          ctx_in,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [BYTE_W-1:0] wr_byte,
  output cpu_ctx_t          ctx_out
);
  cpu_ctx_t ctx_q, ctx_d;
  logic     nmi_q, nmi_d;
  logic     ctx_en;

  always_comb begin
    ctx_en = 1'b1;
    ctx_d  = ctx_q;
    nmi_d  = nmi_q;
    if (take_entry) begin
      ctx_d = ctx_in;
      nmi_d = entry_nmi;
    end else if (mode == SEQ_PULL) begin
      ctx_d = slot_put(ctx_q, slot, rd_byte);
    end else if (mode == SEQ_PUSH && last_step) begin
      ctx_d.ccr[I_BIT] = 1'b1;
      if (nmi_q) ctx_d.ccr[X_BIT] = 1'b1;
    end else begin
      ctx_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_q <= '0;
      nmi_q <= 1'b0;
    end else if (ctx_en) begin
      ctx_q <= ctx_d;
      nmi_q <= nmi_d;
    end
  end

  assign wr_byte = slot_get(ctx_q, slot);
  assign ctx_out = ctx_q;
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irqs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int I_BIT  = 4,
  parameter int X_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              entry_req,
  input  logic              entry_nmi,
  input  logic              instr_done,
  input  logic              ret_req,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [15:0]       pc_in,
  input  logic [15:0]       y_in,
  input  logic [15:0]       x_in,
  input  logic [7:0]        a_in,
  input  logic [7:0]        b_in,
  input  logic [7:0]        ccr_in,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] sp_out,
  output logic [15:0]       pc_out,
  output logic [15:0]       y_out,
  output logic [15:0]       x_out,
  output logic [7:0]        a_out,
  output logic [7:0]        b_out,
  output logic [7:0]        ccr_out
);
  seq_mode_e         mode;
  logic [SLOT_W-1:0] slot;
  logic              take_entry, take_ret, last_step;
  cpu_ctx_t          ctx_in, ctx_out;

  assign ctx_in = '{pc: pc_in, y: y_in, x: x_in, a: a_in, b: b_in, ccr: ccr_in};

  irqs_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .entry_req  (entry_req),
    .instr_done (instr_done),
    .ret_req    (ret_req),
    .mode       (mode),
    .slot       (slot),
    .take_entry (take_entry),
    .take_ret   (take_ret),
    .last_step  (last_step),
    .done       (done)
  );

  irqs_sp #(.ADDR_W(ADDR_W)) u_sp (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode),
    .load   (take_entry | take_ret),
    .sp_in  (sp_in),
    .addr   (mem_addr),
    .sp_out (sp_out)
  );

  irqs_ctx #(.I_BIT(I_BIT), .X_BIT(X_BIT)) u_ctx (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .slot       (slot),
    .take_entry (take_entry),
    .entry_nmi  (entry_nmi),
    .last_step  (last_step),
    .ctx_in     (ctx_in),
    .rd_byte    (mem_rdata),
    .wr_byte    (mem_wdata),
    .ctx_out    (ctx_out)
  );

  assign busy    = (mode != SEQ_IDLE);
  assign mem_we  = (mode == SEQ_PUSH);
  assign mem_re  = (mode == SEQ_PULL);
  assign pc_out  = ctx_out.pc;
  assign y_out   = ctx_out.y;
  assign x_out   = ctx_out.x;
  assign a_out   = ctx_out.a;
  assign b_out   = ctx_out.b;
  assign ccr_out = ctx_out.ccr;
endmodule

// File: rtl/irq_stack_seq_chk.sv
module irq_stack_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int I_BIT  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] sp_out,
  input logic [7:0]        ccr_out
);
  logic              prev_we, prev_re, prev_busy;
  logic [ADDR_W-1:0] prev_sp;
  logic [3:0]        run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_we   <= 1'b0;
      prev_re   <= 1'b0;
      prev_busy <= 1'b0;
      prev_sp   <= '0;
      run_cnt   <= '0;
    end else begin
      prev_we   <= mem_we;
      prev_re   <= mem_re;
      prev_busy <= busy;
      prev_sp   <= sp_out;
      run_cnt   <= busy ? run_cnt + 1'b1 : 4'd0;
    end
  end

  assert_port_in_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy);
  assert_run_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_busy && !busy) |-> (run_cnt == 4'd9));
  assert_run_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= 4'd9);
  assert_push_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prev_we |-> (sp_out == prev_sp - 1'b1));
  assert_pull_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prev_re |-> (sp_out == prev_sp + 1'b1));
  assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_we && !busy) |-> ccr_out[I_BIT]);
  assert_no_pull_in_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_we && busy) |-> !mem_re);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (prev_busy && !busy));
endmodule

bind irq_stack_seq irq_stack_seq_chk #(.ADDR_W(ADDR_W), .I_BIT(I_BIT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .done    (done),
  .mem_we  (mem_we),
  .mem_re  (mem_re),
  .sp_out  (sp_out),
  .ccr_out (ccr_out)
);

// File: tb/irq_stack_seq_tb.sv
module irq_stack_seq_tb;
  logic        clk, rst_n;
  logic        entry_req, entry_nmi, instr_done, ret_req;
  logic [15:0] sp_in, pc_in, y_in, x_in;
  logic [7:0]  a_in, b_in, ccr_in;
  logic        mem_we, mem_re, busy, done;
  logic [15:0] mem_addr, sp_out, pc_out, y_out, x_out;
  logic [7:0]  mem_wdata, mem_rdata, a_out, b_out, ccr_out;
  logic [7:0]  tb_mem [256];

  int n_chk = 0;
  int n_fail = 0;

  irq_stack_seq u_dut (
    .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .entry_nmi(entry_nmi),
    .instr_done(instr_done), .ret_req(ret_req), .sp_in(sp_in), .pc_in(pc_in),
    .y_in(y_in), .x_in(x_in), .a_in(a_in), .b_in(b_in), .ccr_in(ccr_in),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .sp_out(sp_out),
    .pc_out(pc_out), .y_out(y_out), .x_out(x_out), .a_out(a_out), .b_out(b_out),
    .ccr_out(ccr_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign mem_rdata = tb_mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) tb_mem[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int k, logic [15:0] p, logic [15:0] y,
                                          logic [15:0] x, logic [7:0] a, logic [7:0] b, logic [7:0] c);
    case (k)
      0: return p[7:0];
      1: return p[15:8];
      2: return y[7:0];
      3: return y[15:8];
      4: return x[7:0];
      5: return x[15:8];
      6: return a;
      7: return b;
      default: return c;
    endcase
  endfunction

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] sp0, p0, y0, x0, new_sp;
    logic [7:0]  a0, b0, c0, cexp, stk_c;
    logic        nmi0;
    rst_n = 1'b0; entry_req = 0; entry_nmi = 0; instr_done = 0; ret_req = 0;
    sp_in = '0; pc_in = '0; y_in = '0; x_in = '0; a_in = '0; b_in = '0; ccr_in = '0;
    for (int j = 0; j < 256; j++) tb_mem[j] = 8'h00;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy && !done && !mem_we && !mem_re, "R11 idle strobes", {busy, done, mem_we, mem_re}, 0);
    chk(sp_out == 0 && pc_out == 0 && ccr_out == 0 && x_out == 0, "R11 zero regs", {sp_out, pc_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_we, "R11 after release", {busy, mem_we}, 0);

    for (int i = 0; i < 6; i++) begin
      sp0  = (i == 5) ? 16'h0004 : 16'h0180 + 16'(i * 19);
      p0   = 16'h1234 + 16'(i * 16'h0321);
      y0   = 16'hA050 ^ 16'(i * 16'h1111);
      x0   = 16'h0F0F + 16'(i * 16'h0102);
      a0   = 8'h11 * 8'(i + 1);
      b0   = 8'hE0 - 8'(i * 7);
      c0   = 8'(i * 37) & 8'hAF;
      nmi0 = i[0];
      sp_in = sp0; pc_in = p0; y_in = y0; x_in = x0; a_in = a0; b_in = b0; ccr_in = c0;
      entry_nmi = nmi0;
      // R1 stall: request without completion
      entry_req = 1'b1; instr_done = 1'b0;
      for (int s = 0; s < 3; s++) begin
        @(negedge clk);
        chk(!busy && !mem_we, "R1 waits for instr_done", {busy, mem_we}, 0);
      end
      instr_done = 1'b1;
      @(negedge clk);
      entry_req = 1'b0; instr_done = 1'b0; entry_nmi = 1'b0;
      for (int k = 0; k < 9; k++) begin
        chk(busy && mem_we && !mem_re, "R3 push strobe", {busy, mem_we, mem_re}, 3'b110);
        chk(mem_addr == sp0 - 16'(k + 1), "R2 push addr", mem_addr, sp0 - 16'(k + 1));
        chk(mem_wdata == exp_byte(k, p0, y0, x0, a0, b0, c0), "R2 push data",
            mem_wdata, exp_byte(k, p0, y0, x0, a0, b0, c0));
        // R8 requests during entry must be ignored
        ret_req   = (k == 3);
        entry_req = (k == 5);
        instr_done = (k == 5);
        pc_in = 16'hDEAD; ccr_in = 8'hFF; sp_in = 16'h0000;
        @(negedge clk);
      end
      ret_req = 0; entry_req = 0; instr_done = 0;
      chk(!busy && !mem_we && !mem_re, "R3 R8 busy ends after nine", {busy, mem_we, mem_re}, 0);
      chk(done, "R10 done after entry", done, 1);
      new_sp = sp0 - 16'd9;
      chk(sp_out == new_sp, "R4 sp after entry", sp_out, new_sp);
      cexp = c0 | 8'h10 | (nmi0 ? 8'h40 : 8'h00);
      chk(ccr_out == cexp, "R5 masks after entry", ccr_out, cexp);
      chk(tb_mem[new_sp[7:0]] == c0, "R5 stacked ccr raw", tb_mem[new_sp[7:0]], c0);
      @(negedge clk);
      chk(!done && !busy, "R10 done one cycle", {done, busy}, 0);

      // return, optionally with an edited stacked ccr
      stk_c = (i % 2 == 0) ? (c0 ^ 8'h50) : c0;
      tb_mem[new_sp[7:0]] = stk_c;
      sp_in = new_sp; pc_in = 16'h5555; y_in = 16'h6666; x_in = 16'h7777;
      a_in = 8'h88; b_in = 8'h99; ccr_in = 8'hFF;
      ret_req = 1'b1;
      @(negedge clk);
      ret_req = 1'b0;
      for (int k = 0; k < 9; k++) begin
        chk(busy && mem_re && !mem_we, "R3 pull strobe", {busy, mem_we, mem_re}, 3'b101);
        chk(mem_addr == new_sp + 16'(k), "R6 pull addr", mem_addr, new_sp + 16'(k));
        @(negedge clk);
      end
      chk(!busy && done, "R10 done after return", {busy, done}, 2'b01);
      chk(sp_out == sp0, "R6 sp after return", sp_out, sp0);
      chk(pc_out == p0 && y_out == y0 && x_out == x0, "R7 16-bit regs", {pc_out, x_out}, {p0, x0});
      chk(a_out == a0 && b_out == b0, "R7 accumulators", {a_out, b_out}, {a0, b0});
      chk(ccr_out == stk_c, "R7 ccr masks from stack", ccr_out, stk_c);
      @(negedge clk);
    end

    // R9 simultaneous entry and return
    sp_in = 16'h01C0; ccr_in = 8'h00; entry_nmi = 1'b0;
    entry_req = 1'b1; instr_done = 1'b1; ret_req = 1'b1;
    @(negedge clk);
    entry_req = 0; instr_done = 0; ret_req = 0;
    chk(mem_we && !mem_re, "R9 entry wins", {mem_we, mem_re}, 2'b10);
    chk(mem_addr == 16'h01BF, "R9 entry address", mem_addr, 16'h01BF);
    repeat (9) @(negedge clk);
    chk(!busy && ccr_out == 8'h10, "R9 R5 I only", ccr_out, 8'h10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule